// File: doc/BRIEF.md
# Per-Pin Input Debounce Filter

This block sits between one already-synchronised input pin and the logic that samples its level (the input-status view and the edge detector). It suppresses short bounces: a new level on the raw input is passed on only after it has held, without interruption, for a programmable window. The window is measured in one-millisecond ticks supplied by a prescaler shared across all pins.

The window length is programmed as a 3-bit exponent, so a setting of n gives 2^n ticks (1 ms up to 128 ms). A separate enable bit switches the filter in or out. With the filter switched out, the output follows the raw input in the same cycle. Whenever the window setting or the enable bit changes, the count in progress is thrown away without disturbing the output.

Top module: `dbf_pin_filter`

## Requirements
- R1: While the synchronous active-high reset is asserted, the filtered level is loaded from the raw input and the window count clears. With the filter enabled, the output therefore equals the raw level present at the last reset edge.
- R2: While the enable input is 0, the filtered output equals the raw input combinationally, in the same cycle.
- R3: With the filter enabled, suppose the raw input differs from the filtered output and stays that way. The output takes the raw level on the clock edge that samples the 2^n-th tick, where n is the unsigned value of the 3-bit rate field.
- R4: Fewer than 2^n ticks leave the output unchanged. Clock cycles with the tick input low do not advance the window, however many of them pass.
- R5: Any cycle in which the raw input equals the filtered level discards the ticks collected so far. A later difference then needs a full 2^n fresh ticks.
- R6: A cycle in which the rate field or the enable bit differs from its value in the previous cycle restarts the window. That cycle's tick is not counted, and the output does not change in that cycle.
- R7: All eight rate codes are honoured: code 0 gives 1 tick, code 7 gives 128 ticks, and each step doubles the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick | input | 1 | One-cycle pulse per millisecond from the shared prescaler |
| pin_raw | input | 1 | Synchronised raw pin level |
| flt_en | input | 1 | 1 = filter active, 0 = bypass |
| flt_rate | input | 3 | Window exponent n; window is 2^n ticks |
| pin_flt | output | 1 | Filtered pin level |

## Verification
All eight rate codes are swept in both the rising and the falling direction. Each run gives one tick fewer than the window and then the final tick. This separates an exact 2^n window from an off-by-one or a wrong exponent decode. Further runs cover the following:
- a long stretch with no ticks, which shows that only ticks advance the count;
- a one-cycle return of the raw input to the filtered level partway through a window, which must restart the window;
- a rate change during a count, together with a tick in the same cycle, which shows the restart and that no output glitch occurs;
- bypass toggling;
- a reset taken while the raw input differs from the held level.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    localparam int DBF_RATE_W = 3;
    localparam int DBF_MAX_EXP = (1 << DBF_RATE_W) - 1;
    localparam int DBF_CNT_W = DBF_MAX_EXP + 1;

    typedef logic [DBF_RATE_W-1:0] rate_t;
    typedef logic [DBF_CNT_W-1:0] wcnt_t;

    typedef struct packed {
        logic  en;
        rate_t rate;
    } flt_cfg_t;

    function automatic wcnt_t win_len(input rate_t r);
        return wcnt_t'(1) << r;
    endfunction

endpackage

// File: rtl/dbf_cfg_watch.sv
module dbf_cfg_watch
    import dbf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  flt_cfg_t cfg,
    output logic     restart
);

    flt_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg;
        end else begin
            cfg_q <= cfg;
        end
    end

    assign restart = (cfg != cfg_q);

endmodule

// File: rtl/dbf_win_cnt.sv
module dbf_win_cnt
    import dbf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  tick,
    input  wcnt_t limit,
    output wcnt_t cnt,
    output logic  expire
);

    wcnt_t cnt_q;

    assign expire = tick && !clr && (cnt_q == limit - wcnt_t'(1));
    assign cnt    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr || expire) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + wcnt_t'(1);
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt_q < limit || clr || $changed(limit)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !tick && !clr |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/dbf_pin_filter.sv
module dbf_pin_filter
    import dbf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ms_tick,
    input  logic                  pin_raw,
    input  logic                  flt_en,
    input  logic [DBF_RATE_W-1:0] flt_rate,
    output logic                  pin_flt
);

    flt_cfg_t cfg;
    logic     cfg_restart;
    logic     lvl_q;
    logic     win_clr;
    logic     win_expire;
    wcnt_t    win_cnt;
    wcnt_t    win_limit;

    assign cfg.en    = flt_en;
    assign cfg.rate  = flt_rate;
    assign win_limit = win_len(flt_rate);

    dbf_cfg_watch u_watch (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .restart (cfg_restart)
    );

    assign win_clr = !flt_en || (pin_raw == lvl_q) || cfg_restart;

    dbf_win_cnt u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (win_clr),
        .tick   (ms_tick),
        .limit  (win_limit),
        .cnt    (win_cnt),
        .expire (win_expire)
    );

    always_ff @(posedge clk) begin
        if (rst || !flt_en || win_expire) begin
            lvl_q <= pin_raw;
        end
    end

    assign pin_flt = flt_en ? lvl_q : pin_raw;

    AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !flt_en |-> pin_flt == pin_raw); // R2

    AST_NO_EARLY_FLIP: assert property (@(posedge clk) disable iff (rst)
        flt_en && $past(flt_en) && !$past(rst) && $changed(lvl_q)
        |-> $past(ms_tick) && ($past(win_cnt) == $past(win_limit) - wcnt_t'(1))); // R3

    AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flt_en && pin_raw == lvl_q |=> win_cnt == '0); // R5

    AST_CFG_RESTART: assert property (@(posedge clk) disable iff (rst)
        cfg_restart && flt_en && $past(flt_en) |=> win_cnt == '0 && $stable(lvl_q)); // R6

endmodule

// File: tb/sim_dbf_pin_filter.sv
module sim_dbf_pin_filter;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ms_tick = 1'b0;
    logic       pin_raw = 1'b1;
    logic       flt_en = 1'b1;
    logic [2:0] flt_rate = 3'd0;
    logic       pin_flt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbf_pin_filter u0 (
        .clk      (clk),
        .rst      (rst),
        .ms_tick  (ms_tick),
        .pin_raw  (pin_raw),
        .flt_en   (flt_en),
        .flt_rate (flt_rate),
        .pin_flt  (pin_flt)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: pin_flt=%b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // one clock cycle; inputs change 1 time unit after the edge
    task automatic cyc(input logic tk);
        ms_tick = tk;
        @(posedge clk);
        #1;
        ms_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1);
            cyc(1'b0);
        end
    endtask

    initial begin
        logic cur;
        @(posedge clk); #1;
        cyc(1'b0); cyc(1'b0);
        rst = 1'b0;
        cyc(1'b0);
        chk("R1 reset loads raw", pin_flt, 1'b1);

        // R3 / R7 sweep over all rate codes, both directions
        for (int r = 0; r < 8; r++) begin
            flt_rate = 3'(r);
            cyc(1'b0); cyc(1'b0);
            for (int d = 0; d < 2; d++) begin
                cur = pin_flt;
                pin_raw = ~cur;
                ticks((1 << r) - 1);
                chk("R4 short of window", pin_flt, cur);
                cyc(1'b1);
                chk("R3 R7 window expiry", pin_flt, ~cur);
                cyc(1'b0);
                chk("R3 level held", pin_flt, ~cur);
            end
        end

        // R4: no ticks, no progress
        flt_rate = 3'd0;
        cyc(1'b0); cyc(1'b0);
        cur = pin_flt;
        pin_raw = ~cur;
        for (int i = 0; i < 40; i++) cyc(1'b0);
        chk("R4 idle cycles", pin_flt, cur);
        cyc(1'b1);
        chk("R4 single tick after idle", pin_flt, ~cur);

        // R5: bounce back restarts
        flt_rate = 3'd2;
        cyc(1'b0); cyc(1'b0);
        cur = pin_flt;
        pin_raw = ~cur;
        ticks(3);
        pin_raw = cur;
        cyc(1'b0);
        pin_raw = ~cur;
        ticks(3);
        chk("R5 restart after bounce", pin_flt, cur);
        cyc(1'b1);
        chk("R5 full window after bounce", pin_flt, ~cur);

        // R6: rate change restarts, tick in change cycle ignored
        flt_rate = 3'd3;
        cyc(1'b0); cyc(1'b0);
        cur = pin_flt;
        pin_raw = ~cur;
        ticks(6);
        flt_rate = 3'd2;
        cyc(1'b1);
        chk("R6 no glitch on rate change", pin_flt, cur);
        ticks(3);
        chk("R6 restarted window", pin_flt, cur);
        cyc(1'b1);
        chk("R6 expiry after restart", pin_flt, ~cur);

        // R2: bypass
        flt_en = 1'b0;
        pin_raw = 1'b1; #1;
        chk("R2 bypass high", pin_flt, 1'b1);
        pin_raw = 1'b0; #1;
        chk("R2 bypass low", pin_flt, 1'b0);
        cyc(1'b0);
        pin_raw = 1'b1; #1;
        chk("R2 bypass same cycle", pin_flt, 1'b1);
        cyc(1'b0);
        flt_en = 1'b1; #1;
        chk("R6 no glitch on enable", pin_flt, 1'b1);
        cyc(1'b1);
        chk("R6 enable holds level", pin_flt, 1'b1);

        // R1: reset with raw differing from held level, long window
        flt_rate = 3'd7;
        cyc(1'b0);
        pin_raw = 1'b0;
        rst = 1'b1;
        cyc(1'b0);
        rst = 1'b0;
        cyc(1'b0);
        chk("R1 reset reloads raw", pin_flt, 1'b0);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected done=1 got 0");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule